// File: doc/BRIEF.md
# Subtract-and-Branch-on-Negative Processor Core

This core is a complete processor with a single instruction. Every instruction word names a destination register, two source registers and an absolute branch address. In each executing cycle the core subtracts the second source from the first, writes the difference to the destination, and then picks the next instruction. If the difference is negative, it jumps to the encoded address. Otherwise it moves on to the next word. Although it has only this one operation, the machine can express any program: register 0 always reads as zero, so an unconditional jump is `r0 = r0 - rK` with `rK` holding 1.

A host fills the core before it runs. While `run` is low, a valid/ready load stream writes either instruction words into the internal program store or seed values into the register file. The program counter and the registers stay frozen during this phase. While `run` is high, the core executes one instruction per clock. The load stream is back-pressured the whole time: `ld_ready` is low, and an offered beat waits and writes nothing. A combinational observation port returns any register, so the host can read results after a run.

Top module: `subneg_cpu`

## Requirements
- R1: After reset the PC is 0 and every register reads 0.
- R2: With `run` low, `ld_ready` is 1, and a beat with `ld_valid` high writes `ld_data` on that clock edge. The beat writes register `ld_addr` when `ld_to_reg` is 1, and program word `ld_addr` when it is 0. With `run` high, `ld_ready` is 0 and an offered beat changes nothing.
- R3: The instruction fields are: bits [31:27] destination, [26:22] source A, [21:17] source B, [16:0] byte branch address. Each run cycle writes A − B, modulo 2^32, to the destination.
- R4: When bit 31 of the difference is 1, the next PC is the branch address with its two low bits forced to 0, taken modulo the program size.
- R5: When the difference is zero or positive, the next PC is PC + 4.
- R6: Register 0 reads as 0 on every port, and writes to it from execution or from loading are dropped.
- R7: While `run` is low, the PC and all registers keep their values, except for an accepted register load.
- R8: An instruction whose destination is also a source reads the value the register held before the instruction.
- R9: Falling through from the last program word wraps the PC to 0.
- R10: Write-back and PC update take effect on the same rising edge, so one instruction completes per run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = execute one instruction per cycle, 0 = hold and accept loads |
| ld_valid | input | 1 | Load beat offered |
| ld_ready | output | 1 | Load beat can be taken (high only while `run` is low) |
| ld_to_reg | input | 1 | 1 = beat targets a register, 0 = a program word |
| ld_addr | input | LD_AW (6) | Register number or program word index |
| ld_data | input | DATA_W (32) | Register value or instruction word |
| obs_sel | input | 5 | Register to observe |
| obs_data | output | DATA_W (32) | Current value of register `obs_sel` |
| pc_o | output | PC_W (8) | Byte address of the current instruction |

## Verification
The bench builds the core with its defaults: 32-bit data and a 64-word program store. With these values the sign boundary at 0x80000000 and the wrapping overflow 0x7FFFFFFF − (−1) can be reached with seeded registers. The last program word, at byte 252, is only a jump away, so the PC wrap back to 0 can be observed in a few cycles. A countdown loop checks the retired-cycle count against a hand trace of the program, including the zero result that must fall through rather than branch.

// File: rtl/subneg_pkg.sv
package subneg_pkg;
  localparam int INSTR_W = 32;
  localparam int RSEL_W  = 5;
  localparam int TGT_W   = 17;

  typedef struct packed {
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src_a;
    logic [RSEL_W-1:0] src_b;
    logic [TGT_W-1:0]  tgt;
  } instr_t;
endpackage

// File: rtl/subneg_imem.sv
module subneg_imem #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/subneg_regfile.sv
module subneg_regfile #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5,
  localparam int NREG  = 2 ** SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ra_sel,
  output logic [DATA_W-1:0] ra_val,
  input  logic [SEL_W-1:0]  rb_sel,
  output logic [DATA_W-1:0] rb_val,
  input  logic [SEL_W-1:0]  ro_sel,
  output logic [DATA_W-1:0] ro_val,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            regs[g] <= '0;
        else if (we && wsel == SEL_W'(g))      regs[g] <= wdata;
      end
    end
  end

  assign ra_val = regs[ra_sel];
  assign rb_val = regs[rb_sel];
  assign ro_val = regs[ro_sel];
endmodule

// File: rtl/subneg_step.sv
module subneg_step #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input  logic [DATA_W-1:0] a_val,
  input  logic [DATA_W-1:0] b_val,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-3:0]   tgt_word,
  output logic [DATA_W-1:0] diff,
  output logic              taken,
  output logic [PC_W-1:0]   pc_next
);
  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] pc_br;

  assign diff    = a_val - b_val;
  assign taken   = diff[DATA_W-1];
  assign pc_seq  = pc + PC_W'(4);
  assign pc_br   = {tgt_word, 2'b00};
  assign pc_next = taken ? pc_br : pc_seq;
endmodule

// File: rtl/subneg_cpu.sv
module subneg_cpu
  import subneg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IMEM_DEPTH = 64,
  localparam int IMEM_AW   = $clog2(IMEM_DEPTH),
  localparam int PC_W      = IMEM_AW + 2,
  localparam int LD_AW     = (IMEM_AW > RSEL_W) ? IMEM_AW : RSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_to_reg,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [RSEL_W-1:0] obs_sel,
  output logic [DATA_W-1:0] obs_data,
  output logic [PC_W-1:0]   pc_o
);
  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] ins_w;
  instr_t             ins;
  logic [DATA_W-1:0]  a_val;
  logic [DATA_W-1:0]  b_val;
  logic [DATA_W-1:0]  diff_w;
  logic               taken_w;
  logic [PC_W-1:0]    pc_next;
  logic               ld_fire;
  logic               rf_we;
  logic [RSEL_W-1:0]  rf_wsel;
  logic [DATA_W-1:0]  rf_wdata;
  logic               unused_tgt;

  assign ld_ready = ~run;
  assign ld_fire  = ld_valid & ld_ready;

  subneg_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) imem_i (
    .clk   (clk),
    .we    (ld_fire & ~ld_to_reg),
    .waddr (ld_addr[IMEM_AW-1:0]),
    .wdata (ld_data[INSTR_W-1:0]),
    .raddr (pc_q[PC_W-1:2]),
    .rdata (ins_w)
  );

  assign ins = instr_t'(ins_w);
  assign unused_tgt = ^{ins.tgt[TGT_W-1:PC_W], ins.tgt[1:0], taken_w};

  always_comb begin
    if (run) begin
      rf_we    = 1'b1;
      rf_wsel  = ins.dst;
      rf_wdata = diff_w;
    end else begin
      rf_we    = ld_fire & ld_to_reg;
      rf_wsel  = ld_addr[RSEL_W-1:0];
      rf_wdata = ld_data;
    end
  end

  subneg_regfile #(.DATA_W(DATA_W), .SEL_W(RSEL_W)) rf_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_sel (ins.src_a),
    .ra_val (a_val),
    .rb_sel (ins.src_b),
    .rb_val (b_val),
    .ro_sel (obs_sel),
    .ro_val (obs_data),
    .we     (rf_we),
    .wsel   (rf_wsel),
    .wdata  (rf_wdata)
  );

  subneg_step #(.DATA_W(DATA_W), .PC_W(PC_W)) step_i (
    .a_val    (a_val),
    .b_val    (b_val),
    .pc       (pc_q),
    .tgt_word (ins.tgt[PC_W-1:2]),
    .diff     (diff_w),
    .taken    (taken_w),
    .pc_next  (pc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (run) pc_q <= pc_next;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/subneg_cpu_chk.sv
module subneg_cpu_chk #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              ld_ready,
  input logic [PC_W-1:0]   pc,
  input logic [31:0]       ins_w,
  input logic [DATA_W-1:0] diff,
  input logic [DATA_W-1:0] a_val
);
  assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !ld_ready);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pc));

  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  assert_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && diff[DATA_W-1]) |=> pc == {$past(ins_w[PC_W-1:2]), 2'b00});

  assert_fallthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !diff[DATA_W-1]) |=> pc == $past(pc) + PC_W'(4));

  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_w[26:22] == 5'd0) |-> a_val == '0);
endmodule

bind subneg_cpu subneg_cpu_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .ld_ready (ld_ready),
  .pc       (pc_o),
  .ins_w    (ins_w),
  .diff     (diff_w),
  .a_val    (a_val)
);

// File: tb/subneg_cpu_tb.sv
module subneg_cpu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_to_reg = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0]  obs_sel = '0;
  logic [31:0] obs_data;
  logic [7:0]  pc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  subneg_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_to_reg(ld_to_reg), .ld_addr(ld_addr), .ld_data(ld_data),
    .obs_sel(obs_sel), .obs_data(obs_data), .pc_o(pc_o)
  );

  function automatic logic [31:0] enc(int rd, int a, int b, int tgt_byte);
    return {5'(rd), 5'(a), 5'(b), 17'(tgt_byte)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0; ld_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(bit to_reg, int addr, logic [31:0] data);
    @(negedge clk);
    ld_valid = 1'b1; ld_to_reg = to_reg; ld_addr = 6'(addr); ld_data = data;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic reg_is(string req, int r, logic [31:0] exp);
    obs_sel = 5'(r);
    #1;
    check(req, obs_data, exp);
  endtask

  task automatic run_for(int n);
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic t_reset();
    int bad = 0;
    do_reset();
    check("R1 pc", 32'(pc_o), 32'd0);
    for (int r = 0; r < 32; r++) begin
      obs_sel = 5'(r);
      #1;
      if (obs_data !== 32'd0) bad++;
    end
    check("R1 regs", 32'(bad), 32'd0);
    check("R2 ready idle", 32'(ld_ready), 32'd1);
  endtask

  task automatic t_countdown();
    int cnt = 0;
    do_reset();
    load(1, 1, 32'd1);
    load(1, 2, 32'd3);
    load(0, 0, enc(2, 2, 1, 8));
    load(0, 1, enc(0, 0, 1, 0));
    load(0, 2, enc(0, 0, 1, 8));
    @(negedge clk);
    run = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      cnt++;
      if (pc_o == 8'd8) break;
    end
    run = 1'b0;
    check("R10 cycles", 32'(cnt), 32'd7);
    reg_is("R3 countdown", 2, 32'hFFFF_FFFF);
    reg_is("R6 r0 after jumps", 0, 32'd0);
    reg_is("R7 r1 kept", 1, 32'd1);
  endtask

  task automatic t_boundary();
    do_reset();
    load(1, 1, 32'd1);
    load(1, 5, 32'h8000_0000);
    load(1, 7, 32'h7FFF_FFFF);
    load(1, 8, 32'hFFFF_FFFF);
    load(1, 12, 32'd5);
    load(1, 13, 32'd7);
    load(0, 0, enc(0, 0, 1, 40));
    load(0, 10, enc(9, 5, 6, 80));
    load(0, 20, enc(10, 7, 8, 120 + 3));
    load(0, 30, enc(11, 6, 6, 0));
    load(0, 31, enc(12, 12, 13, 252));
    load(0, 63, enc(14, 1, 0, 0));
    run_for(3);
    check("R4 branch low bits dropped", 32'(pc_o), 32'd120);
    run_for(1);
    check("R5 zero falls through", 32'(pc_o), 32'd124);
    run_for(1);
    check("R4 negative jumps", 32'(pc_o), 32'd252);
    run_for(1);
    check("R9 wrap", 32'(pc_o), 32'd0);
    reg_is("R3 sign boundary", 9, 32'h8000_0000);
    reg_is("R3 overflow wrap", 10, 32'h8000_0000);
    reg_is("R5 zero result", 11, 32'd0);
    reg_is("R8 self operand", 12, 32'hFFFF_FFFE);
    reg_is("R3 r1-r0", 14, 32'd1);
  endtask

  task automatic t_backpressure();
    do_reset();
    load(1, 1, 32'd1);
    load(0, 0, enc(0, 0, 1, 0));
    @(negedge clk);
    run = 1'b1;
    ld_valid = 1'b1; ld_to_reg = 1'b1; ld_addr = 6'd20; ld_data = 32'h1234;
    @(negedge clk);
    check("R2 ready low", 32'(ld_ready), 32'd0);
    @(negedge clk);
    ld_valid = 1'b0; run = 1'b0;
    reg_is("R2 beat ignored", 20, 32'd0);
    check("R4 self jump", 32'(pc_o), 32'd0);
    load(1, 0, 32'h55);
    reg_is("R6 r0 load dropped", 0, 32'd0);
    load(1, 20, 32'h1234);
    reg_is("R2 beat accepted", 20, 32'h1234);
    load(0, 0, enc(3, 1, 0, 0));
    repeat (3) @(negedge clk);
    check("R7 pc held", 32'(pc_o), 32'd0);
    reg_is("R7 reg held", 3, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_countdown();
    t_boundary();
    t_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule